// File: doc/BRIEF.md
# Tiled Box Sub-Tile Walker

This block takes a rectangular region of a tiled texture, given as an origin (x, y) and a size (width, height) in pixels, and splits it into pieces that each lie inside one sub-tile. A sub-tile is a grid of 4 × 4 micro-tiles. With the default geometry a micro-tile is 4 × 4 pixels at 4 bytes per pixel, so a sub-tile is 16 × 16 pixels and holds 1024 bytes. For every piece the walker emits one descriptor. The descriptor gives the piece's origin inside its sub-tile and the piece's clipped width and height. It also gives the micro-tile coordinates of the sub-tile corner, which an external base-address mapper turns into the tiled-memory address. Finally it gives the byte offset of the piece in a linear raster buffer that has a programmable row stride.

The walker covers the region one band of sub-tile rows at a time, from top to bottom. Inside each band it steps from left to right. Each step lands on the next sub-tile boundary, and pieces are clipped at all four edges of the region. A valid/ready handshake moves each descriptor out. A one-cycle done pulse marks the end of a region. The linear offset is built from two cursors. A column offset restarts at zero in each band and grows by the piece width times the pixel size. A row base grows by the stride times the band height.

Top module: `tile_box_walker`

## Requirements
- R1: While reset is held, and after it is released, `d_valid`, `busy` and `done` are 0.
- R2: A `start` pulse seen while idle, with non-zero width and height, presents the first descriptor on the next cycle. That descriptor has `d_ox` = x mod 16, `d_oy` = y mod 16 and `d_lin` = 0.
- R3: The piece width is min(x_end − x, 16 − `d_ox`) and the piece height is min(y_end − y, 16 − `d_oy`). Here x_end = box_x + box_w and y_end = box_y + box_h. Neither is ever 0.
- R4: Descriptors come band by band, from top to bottom, and left to right inside each band. The next x is the smallest multiple of 16 above the current x, and the next y is found the same way. The count is (⌊(x_end−1)/16⌋ − ⌊x/16⌋ + 1) × (the same expression for y).
- R5: `d_lin` = row_base + col_off. col_off is 0 at the start of each band and grows by 4 × piece width after each accepted piece. row_base starts at 0 and grows by `lin_stride` × band height after each band.
- R6: `d_pitch` always equals the sub-tile row pitch in bytes, 16 × 4 = 64.
- R7: While `d_valid` is 1 and `d_ready` is 0, the descriptor fields stay unchanged on the next cycle and `d_valid` stays 1.
- R8: `done` is a one-cycle pulse in the cycle after the last descriptor is accepted. `busy` and `d_valid` are 0 at that point.
- R9: A `start` with zero width or zero height produces no descriptor. `done` is 1 on the next cycle.
- R10: A `start` seen while busy is ignored. The current walk goes on with its latched region and stride.
- R11: `d_utx` = (x >> 2) with its low two bits cleared, and `d_uty` = (y >> 2) with its low two bits cleared. These are the mapper's micro-tile coordinates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk of the region on the box inputs (used only when idle) |
| box_x | input | 12 | Region origin x in pixels |
| box_y | input | 12 | Region origin y in pixels |
| box_w | input | 12 | Region width in pixels |
| box_h | input | 12 | Region height in pixels |
| lin_stride | input | 32 | Linear buffer row stride in bytes |
| d_ready | input | 1 | Consumer accepts the current descriptor |
| d_valid | output | 1 | Descriptor present |
| d_ox | output | 4 | Piece x origin inside the sub-tile |
| d_oy | output | 4 | Piece y origin inside the sub-tile |
| d_w | output | 5 | Piece width in pixels (1..16) |
| d_h | output | 5 | Piece height in pixels (1..16) |
| d_utx | output | 12 | Sub-tile corner micro-tile x coordinate for the address mapper |
| d_uty | output | 12 | Sub-tile corner micro-tile y coordinate for the address mapper |
| d_lin | output | 32 | Byte offset of the piece in the linear buffer |
| d_pitch | output | 7 | Row pitch of a sub-tile in bytes |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The first descriptor is due one clock edge after the edge that samples an accepted `start`. Each later descriptor is due one edge after the handshake of the one before it. `done` follows the last handshake by one edge, or follows `start` by one edge when the region is empty. The reference model in the bench advances on each rising edge from the start and handshake values it saw there. It compares every output on the falling edge that follows, so each result is checked in exactly the cycle it becomes due. Held descriptors are compared against the values from the previous falling edge whenever the consumer stalled.

// File: rtl/tbw_pkg.sv
package tbw_pkg;

    typedef enum logic {
        WALK_IDLE,
        WALK_EMIT
    } walk_state_e;

    // Bytes in one row of a sub-tile: four micro-tiles wide.
    function automatic int unsigned sub_pitch(int unsigned ut_w_log2, int unsigned bpp);
        return (32'd4 << ut_w_log2) * bpp;
    endfunction

endpackage

// File: rtl/tbw_piece_calc.sv
// Combinational geometry of the piece under the cursor.
module tbw_piece_calc #(
    parameter int unsigned XW  = 14,
    parameter int unsigned SXL = 4,
    parameter int unsigned SYL = 4,
    localparam int unsigned UXW = XW - SXL + 2,
    localparam int unsigned UYW = XW - SYL + 2
) (
    input  logic [XW-1:0]  cx,
    input  logic [XW-1:0]  cy,
    input  logic [XW-1:0]  xe,
    input  logic [XW-1:0]  ye,
    output logic [SXL-1:0] ox,
    output logic [SYL-1:0] oy,
    output logic [SXL:0]   pw,
    output logic [SYL:0]   ph,
    output logic [UXW-1:0] utx,
    output logic [UYW-1:0] uty,
    output logic [XW-1:0]  nx,
    output logic [XW-1:0]  ny,
    output logic           last_col,
    output logic           last_row
);
    logic [SXL:0]  room_x;
    logic [SYL:0]  room_y;
    logic [XW-1:0] rem_x, rem_y;

    always_comb begin
        ox     = cx[SXL-1:0];
        oy     = cy[SYL-1:0];
        room_x = {1'b1, {SXL{1'b0}}} - {1'b0, ox};
        room_y = {1'b1, {SYL{1'b0}}} - {1'b0, oy};
        rem_x  = xe - cx;
        rem_y  = ye - cy;
        pw = (rem_x < {{(XW-SXL-1){1'b0}}, room_x}) ? rem_x[SXL:0] : room_x;
        ph = (rem_y < {{(XW-SYL-1){1'b0}}, room_y}) ? rem_y[SYL:0] : room_y;
        nx = {cx[XW-1:SXL] + 1'b1, {SXL{1'b0}}};
        ny = {cy[XW-1:SYL] + 1'b1, {SYL{1'b0}}};
        last_col = (nx >= xe);
        last_row = (ny >= ye);
        utx = {cx[XW-1:SXL], 2'b00};
        uty = {cy[XW-1:SYL], 2'b00};
    end
endmodule

// File: rtl/tbw_lin_accum.sv
// Linear-buffer cursors: per-band column offset and band row base.
module tbw_lin_accum #(
    parameter int unsigned AW  = 32,
    parameter int unsigned SXL = 4,
    parameter int unsigned SYL = 4,
    parameter int unsigned BPP = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step_col,
    input  logic          step_row,
    input  logic [SXL:0]  pw,
    input  logic [SYL:0]  ph,
    input  logic [AW-1:0] stride,
    output logic [AW-1:0] lin
);
    localparam logic [AW-1:0] BPP_A = AW'(BPP);

    logic [AW-1:0] col_off, row_base;
    logic [AW-1:0] pw_e, ph_e;

    assign pw_e = {{(AW-SXL-1){1'b0}}, pw};
    assign ph_e = {{(AW-SYL-1){1'b0}}, ph};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            col_off  <= '0;
            row_base <= '0;
        end else if (step_row) begin
            col_off  <= '0;
            row_base <= row_base + stride * ph_e;
        end else if (step_col) begin
            col_off  <= col_off + pw_e * BPP_A;
        end
    end

    assign lin = row_base + col_off;
endmodule

// File: rtl/tile_box_walker.sv
module tile_box_walker #(
    parameter int unsigned CW        = 12,
    parameter int unsigned AW        = 32,
    parameter int unsigned UT_W_LOG2 = 2,
    parameter int unsigned UT_H_LOG2 = 2,
    parameter int unsigned BPP       = 4,
    localparam int unsigned SXL   = UT_W_LOG2 + 2,
    localparam int unsigned SYL   = UT_H_LOG2 + 2,
    localparam int unsigned XW    = CW + 2,
    localparam int unsigned UXW   = XW - UT_W_LOG2,
    localparam int unsigned UYW   = XW - UT_H_LOG2,
    localparam int unsigned PITCH = tbw_pkg::sub_pitch(UT_W_LOG2, BPP),
    localparam int unsigned PTW   = $clog2(PITCH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CW-1:0]   box_x,
    input  logic [CW-1:0]   box_y,
    input  logic [CW-1:0]   box_w,
    input  logic [CW-1:0]   box_h,
    input  logic [AW-1:0]   lin_stride,
    input  logic            d_ready,
    output logic            d_valid,
    output logic [SXL-1:0]  d_ox,
    output logic [SYL-1:0]  d_oy,
    output logic [SXL:0]    d_w,
    output logic [SYL:0]    d_h,
    output logic [UXW-1:0]  d_utx,
    output logic [UYW-1:0]  d_uty,
    output logic [AW-1:0]   d_lin,
    output logic [PTW-1:0]  d_pitch,
    output logic            busy,
    output logic            done
);
    import tbw_pkg::*;

    walk_state_e   state;
    logic [XW-1:0] cx, cy, xe, ye, bx;
    logic [AW-1:0] stride_q;
    logic          done_q;

    logic [XW-1:0] nx, ny;
    logic          last_col, last_row;
    logic          nonempty, accept, hs;

    assign nonempty = (box_w != '0) && (box_h != '0);
    assign accept   = (state == WALK_IDLE) && start && nonempty;
    assign hs       = (state == WALK_EMIT) && d_ready;

    tbw_piece_calc #(.XW(XW), .SXL(SXL), .SYL(SYL)) u_piece (
        .cx(cx), .cy(cy), .xe(xe), .ye(ye),
        .ox(d_ox), .oy(d_oy), .pw(d_w), .ph(d_h),
        .utx(d_utx), .uty(d_uty), .nx(nx), .ny(ny),
        .last_col(last_col), .last_row(last_row)
    );

    tbw_lin_accum #(.AW(AW), .SXL(SXL), .SYL(SYL), .BPP(BPP)) u_lin (
        .clk(clk), .rst(rst), .clear(accept),
        .step_col(hs && !last_col),
        .step_row(hs && last_col && !last_row),
        .pw(d_w), .ph(d_h), .stride(stride_q), .lin(d_lin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WALK_IDLE;
            done_q   <= 1'b0;
            cx       <= '0;
            cy       <= '0;
            xe       <= '0;
            ye       <= '0;
            bx       <= '0;
            stride_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                WALK_IDLE: begin
                    if (start && !nonempty) begin
                        done_q <= 1'b1;
                    end else if (accept) begin
                        state    <= WALK_EMIT;
                        cx       <= {2'b00, box_x};
                        bx       <= {2'b00, box_x};
                        cy       <= {2'b00, box_y};
                        xe       <= {2'b00, box_x} + {2'b00, box_w};
                        ye       <= {2'b00, box_y} + {2'b00, box_h};
                        stride_q <= lin_stride;
                    end
                end
                WALK_EMIT: begin
                    if (d_ready) begin
                        if (!last_col) begin
                            cx <= nx;
                        end else if (!last_row) begin
                            cx <= bx;
                            cy <= ny;
                        end else begin
                            state  <= WALK_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    assign d_valid = (state == WALK_EMIT);
    assign busy    = (state == WALK_EMIT);
    assign done    = done_q;
    assign d_pitch = PTW'(PITCH);
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker #(
    parameter int unsigned CW        = 12,
    parameter int unsigned AW        = 32,
    parameter int unsigned UT_W_LOG2 = 2,
    parameter int unsigned UT_H_LOG2 = 2,
    localparam int unsigned SXL = UT_W_LOG2 + 2,
    localparam int unsigned SYL = UT_H_LOG2 + 2,
    localparam int unsigned XW  = CW + 2,
    localparam int unsigned UXW = XW - UT_W_LOG2,
    localparam int unsigned UYW = XW - UT_H_LOG2
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic [CW-1:0]  box_x,
    input logic [CW-1:0]  box_w,
    input logic [CW-1:0]  box_h,
    input logic           d_ready,
    input logic           d_valid,
    input logic [SXL-1:0] d_ox,
    input logic [SYL-1:0] d_oy,
    input logic [SXL:0]   d_w,
    input logic [SYL:0]   d_h,
    input logic [UXW-1:0] d_utx,
    input logic [UYW-1:0] d_uty,
    input logic [AW-1:0]  d_lin,
    input logic           busy,
    input logic           done
);
    localparam logic [SXL+1:0] STW = (SXL+2)'(1 << SXL);
    localparam logic [SYL+1:0] STH = (SYL+2)'(1 << SYL);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> !d_valid && !done && !busy);

    p_first_piece_r2: assert property (@(posedge clk) disable iff (rst)
        start && !busy && (box_w != '0) && (box_h != '0)
        |=> d_valid && (d_lin == '0) && (d_ox == $past(box_x[SXL-1:0])));

    p_clip_r3: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> (d_w != '0) && (d_h != '0)
                    && ({1'b0, d_ox} + {1'b0, d_w} <= STW)
                    && ({1'b0, d_oy} + {1'b0, d_h} <= STH));

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        d_valid && !d_ready |=> d_valid
            && $stable(d_ox) && $stable(d_oy) && $stable(d_w) && $stable(d_h)
            && $stable(d_utx) && $stable(d_uty) && $stable(d_lin));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !d_valid ##1 !done);

    p_empty_r9: assert property (@(posedge clk) disable iff (rst)
        start && !busy && ((box_w == '0) || (box_h == '0)) |=> done && !d_valid);

    p_align_r11: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> (d_utx[1:0] == 2'b00) && (d_uty[1:0] == 2'b00));
endmodule

bind tile_box_walker tbw_checker #(
    .CW(CW), .AW(AW), .UT_W_LOG2(UT_W_LOG2), .UT_H_LOG2(UT_H_LOG2)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .box_x(box_x), .box_w(box_w),
    .box_h(box_h), .d_ready(d_ready), .d_valid(d_valid), .d_ox(d_ox),
    .d_oy(d_oy), .d_w(d_w), .d_h(d_h), .d_utx(d_utx), .d_uty(d_uty),
    .d_lin(d_lin), .busy(busy), .done(done)
);

// File: tb/tile_box_walker_test.sv
module tile_box_walker_test;
    localparam int SUB = 16;
    localparam int BYTES = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] box_x = '0, box_y = '0, box_w = '0, box_h = '0;
    logic [31:0] lin_stride = '0;
    logic        d_ready = 1'b1;
    logic        d_valid, busy, done;
    logic [3:0]  d_ox, d_oy;
    logic [4:0]  d_w, d_h;
    logic [11:0] d_utx, d_uty;
    logic [31:0] d_lin;
    logic [6:0]  d_pitch;

    always #4 clk = ~clk;

    tile_box_walker uut (
        .clk(clk), .rst(rst), .start(start), .box_x(box_x), .box_y(box_y),
        .box_w(box_w), .box_h(box_h), .lin_stride(lin_stride), .d_ready(d_ready),
        .d_valid(d_valid), .d_ox(d_ox), .d_oy(d_oy), .d_w(d_w), .d_h(d_h),
        .d_utx(d_utx), .d_uty(d_uty), .d_lin(d_lin), .d_pitch(d_pitch),
        .busy(busy), .done(done)
    );

    typedef struct {
        int ox, oy, w, h, utx, uty;
        longint lin;
    } piece_t;

    piece_t q[$];
    int     total = 0, bad = 0;
    int     accepted = 0;
    int     cycles = 0;
    bit     m_busy = 0, exp_done = 0, hs_q = 0;
    bit     stalled = 0, checking = 0;
    bit     ready_rand = 0;
    logic [7:0] lfsr = 8'hA5;
    int     p_ox, p_oy, p_w, p_h, p_utx, p_uty;
    longint p_lin;

    task automatic chk(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int min2(int a, int b);
        return (a < b) ? a : b;
    endfunction

    // Behavioural expectation of every piece of a region, in emission order.
    task automatic build(int bx, int by, int bw, int bh, longint stride);
        int y, x, oy, ox, h, w;
        longint rowb, col;
        if (bw == 0 || bh == 0) return;
        y = by;
        rowb = 0;
        while (y < by + bh) begin
            oy = y % SUB;
            h = min2(by + bh - y, SUB - oy);
            x = bx;
            col = 0;
            while (x < bx + bw) begin
                ox = x % SUB;
                w = min2(bx + bw - x, SUB - ox);
                q.push_back('{ox, oy, w, h, (x / 4) & ~3, (y / 4) & ~3, rowb + col});
                col += w * BYTES;
                x = x - ox + SUB;
            end
            rowb += stride * h;
            y = y - oy + SUB;
        end
    endtask

    function automatic int piece_count(int bx, int by, int bw, int bh);
        if (bw == 0 || bh == 0) return 0;
        return ((bx + bw - 1) / SUB - bx / SUB + 1) * ((by + bh - 1) / SUB - by / SUB + 1);
    endfunction

    // Reference model: advances on the rising edge.
    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_busy = 0;
            exp_done = 0;
        end else begin
            bit was_busy;
            was_busy = m_busy;
            exp_done = 0;
            if (hs_q) begin
                if (q.size() > 0) void'(q.pop_front());
                accepted++;
                if (q.size() == 0) begin
                    m_busy = 0;
                    exp_done = 1;
                end
            end
            if (!was_busy && start) begin
                build(int'(box_x), int'(box_y), int'(box_w), int'(box_h), longint'(lin_stride));
                if (q.size() == 0) exp_done = 1;
                else m_busy = 1;
            end
        end
    end

    // Comparison and consumer drive on the falling edge.
    always @(negedge clk) begin
        if (checking && !rst) begin
            chk("R8 done", done, exp_done);
            chk("R4 valid", d_valid, m_busy);
            chk("R8 busy", busy, m_busy);
            if (m_busy && d_valid && q.size() > 0) begin
                chk("R2 ox", d_ox, q[0].ox);
                chk("R2 oy", d_oy, q[0].oy);
                chk("R3 width", d_w, q[0].w);
                chk("R3 height", d_h, q[0].h);
                chk("R11 utx", d_utx, q[0].utx);
                chk("R11 uty", d_uty, q[0].uty);
                chk("R5 lin", d_lin, q[0].lin & 64'hFFFF_FFFF);
                chk("R6 pitch", d_pitch, SUB * BYTES);
            end
            if (stalled) begin
                chk("R7 hold ox", d_ox, p_ox);
                chk("R7 hold oy", d_oy, p_oy);
                chk("R7 hold w", d_w, p_w);
                chk("R7 hold h", d_h, p_h);
                chk("R7 hold utx", d_utx, p_utx);
                chk("R7 hold uty", d_uty, p_uty);
                chk("R7 hold lin", d_lin, p_lin);
                chk("R7 hold valid", d_valid, 1);
            end
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        d_ready = ready_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
        hs_q = d_valid && d_ready;
        stalled = d_valid && !d_ready;
        p_ox = d_ox; p_oy = d_oy; p_w = d_w; p_h = d_h;
        p_utx = d_utx; p_uty = d_uty; p_lin = d_lin;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic launch(int bx, int by, int bw, int bh, int stride);
        box_x = 12'(bx); box_y = 12'(by); box_w = 12'(bw); box_h = 12'(bh);
        lin_stride = 32'(stride);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, done, 1);
        @(negedge clk);
    endtask

    task automatic run(string tag, int bx, int by, int bw, int bh, int stride);
        @(negedge clk);
        accepted = 0;
        launch(bx, by, bw, bh, stride);
        wait_done({tag, " done seen R8"});
        chk({tag, " R4 count"}, accepted, piece_count(bx, by, bw, bh));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", d_valid, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 busy in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", d_valid, 0);
        chk("R1 busy after reset", busy, 0);
        checking = 1;

        run("aligned single R2", 0, 0, 16, 16, 64);
        run("unaligned multi R3", 5, 3, 40, 21, 200);
        ready_rand = 1;
        run("stalled multi R7", 5, 3, 40, 21, 200);
        run("one pixel R3", 15, 15, 1, 1, 4);
        run("tall narrow R5", 30, 2, 3, 50, 1000);
        run("zero width R9", 17, 0, 0, 5, 64);
        run("zero height R9", 3, 3, 7, 0, 64);
        ready_rand = 0;
        run("boundary crossing R4", 14, 14, 4, 4, 16);

        // R10: start while busy must not disturb the running walk.
        @(negedge clk);
        accepted = 0;
        launch(8, 8, 48, 40, 256);
        repeat (2) @(negedge clk);
        chk("R10 busy before second start", busy, 1);
        box_x = 12'd100; box_y = 12'd100; box_w = 12'd5; box_h = 12'd5;
        lin_stride = 32'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R10 done");
        chk("R10 count of first region", accepted, piece_count(8, 8, 48, 40));

        ready_rand = 1;
        run("wide far edge R11", 4090, 4090, 4095, 3, 20000);
        ready_rand = 0;

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule